// File: doc/BRIEF.md
# Interval counter channel

One channel of a programmable interval timer. It holds a 16-bit down counter and draws a mode-specific waveform on `out`. The counter advances only on system clock edges where `tick` is high, so `tick` stands in for the channel's counting clock. `gate` arms, pauses or restarts the counter, depending on the mode. A neighbouring bus block delivers two things through single-cycle strobes: a mode word, made of a 3-bit mode code and a decimal flag, and a complete 16-bit count. Byte sequencing of the count and reading the count back are done by that neighbour, not here.

The channel supports six waveforms:

| Mode | Waveform |
|------|----------|
| 0 | Level that rises at the end of the count |
| 1 | Retriggerable low pulse started by `gate` |
| 2 | Divide-by-N rate pulse |
| 3 | Square wave with odd-count asymmetry |
| 4 | Single strobe started by writing the count |
| 5 | Single strobe started by `gate` |

With the decimal flag set, the counter steps through four decimal digits instead of binary.

Top module: `ictr_channel`

## Requirements
- R1: After synchronous reset, `out` is 1 and no count is held, so ticks and gate activity leave `out` at 1.
- R2: A mode write decodes `cfg_mode` as follows:
  - 000 is mode 0 and 001 is mode 1.
  - 100 is mode 4 and 101 is mode 5.
  - 010 and 110 are mode 2; 011 and 111 are mode 3.

  One clock after the write, `out` is 0 for mode 0 and 1 for every other mode. Any held count and any count in progress are discarded.
- R3: `out` changes only on a clock where a write or a tick is taken. A tick that arrives in the same cycle as a mode write or a count write is dropped.
- R4: Mode 0: a count write drives `out` to 0. The first following tick loads the count N. The N-th tick after the load raises `out`, and `out` stays high until the next write. For example, with N=4, `out` rises on the fifth tick after the write.
- R5: Mode 1: the counter is triggered on a tick where `gate` is high and was low at the previous taken tick. On that trigger tick the count loads and `out` goes 0. `out` returns to 1 on the N-th tick after the trigger. A new trigger reloads the count.
- R6: Mode 2: a count write makes the next tick load N and set `out` high. `out` is 0 for exactly one tick of every N ticks, and the count reloads by itself (N ≥ 2).
- R7: Mode 3: `out` toggles with a high half of ceil(N/2) ticks and a low half of floor(N/2) ticks. For example, N=11 gives 6 ticks high and 5 ticks low (N ≥ 2).
- R8: Mode 4: a count write makes the next tick load N. On the N-th tick after that, `out` drops to 0 for a single tick and then stays at 1.
- R9: Mode 5: a gate trigger, as defined in R5, loads N. On the N-th tick after the trigger, `out` is 0 for one tick. A trigger can start the strobe again.
- R10: In modes 0, 2, 3 and 4, a tick with `gate` low does not advance the count. In modes 2 and 3 that tick also forces `out` to 1, and a later rising `gate` reloads N.
- R11: Count value 0 stands for the largest count: 65536 in binary, or 10000 with the decimal flag. With the flag set, the count is four decimal digits, so 0x0012 means twelve ticks.
- R12: Codes 110 and 111 produce the same waveforms as 010 and 011.
- R13: In modes 1 and 5, a count write alone starts nothing: `out` stays 1 until a gate trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Counting clock enable, one count step per high cycle |
| gate | input | 1 | Gate level, sampled on ticks |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_mode | input | 3 | Mode code |
| cfg_bcd | input | 1 | Decimal counting flag |
| cnt_we | input | 1 | Count write strobe |
| cnt_val | input | 16 | Count value (0 = largest) |
| out | output | 1 | Channel output, registered |

## Verification
A corrupt down counter or a wrong reload value moves the next edge on `out`. In modes 2 and 3 this appears within one period, which is at most N ticks. In modes 0, 1, 4 and 5 it appears when the count ends. A stuck stretch flag in mode 3 shifts the duty cycle by one tick, and this shows at the first high-to-low toggle. Errors in the gate edge register show as a missed trigger or a missed restart on the first tick with `gate` high. Because of this, the bench compares `out` against an independent tick-level model on every clock, so a divergence is flagged in the cycle it first appears.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  typedef enum logic [2:0] {
    MD_TERM     = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } ictr_mode_e;

  // Codes with the middle bit set fold onto modes 2 and 3.
  function automatic ictr_mode_e norm_mode(input logic [2:0] code);
    if (code[1]) return ictr_mode_e'({1'b0, code[1:0]});
    else         return ictr_mode_e'(code);
  endfunction

endpackage

// File: rtl/ictr_dec.sv
// Decrement by one, either binary or across decimal digits.
module ictr_dec #(
  parameter int DIG = 4
) (
  input  logic [4*DIG-1:0] val,
  input  logic             bcd,
  output logic [4*DIG-1:0] nxt
);
  localparam int W = 4 * DIG;

  logic [DIG-1:0] brw;
  logic [W-1:0]   dec_bcd;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < DIG; g++) begin : g_digit
    logic [3:0] d;
    assign d = val[4*g +: 4];
    assign dec_bcd[4*g +: 4] = brw[g] ? ((d == 4'd0) ? 4'd9 : d - 4'd1) : d;
    if (g < DIG - 1) begin : g_chain
      assign brw[g+1] = brw[g] & (d == 4'd0);
    end
  end

  assign nxt = bcd ? dec_bcd : (val - {{(W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/ictr_gate_edge.sv
// Samples the gate on taken ticks and flags a low-to-high change.
module ictr_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst)       gate_q <= 1'b0;
    else if (step) gate_q <= gate;
  end

  assign rise = gate & ~gate_q;

endmodule

// File: rtl/ictr_channel.sv
module ictr_channel
  import ictr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         gate,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_mode,
  input  logic         cfg_bcd,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_val,
  output logic         out
);
  localparam int DIG = W / 4;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  ictr_mode_e   mode_q;
  logic         bcd_q;
  logic [W-1:0] reload_q;
  logic [W-1:0] cnt_q;
  logic         out_q;
  logic         have_q;
  logic         pend_q;
  logic         run_q;
  logic         strb_q;
  logic         strch_q;

  logic         step;
  logic         rise;
  logic         restart;
  logic [W-1:0] dec1;
  logic [W-1:0] dec2;
  logic [W-1:0] even_rl;

  assign step    = tick & ~cfg_we & ~cnt_we;
  assign restart = pend_q | (rise & have_q);
  assign even_rl = {reload_q[W-1:1], 1'b0};

  ictr_dec #(.DIG(DIG)) u_dec1 (.val(cnt_q), .bcd(bcd_q), .nxt(dec1));
  ictr_dec #(.DIG(DIG)) u_dec2 (.val(dec1),  .bcd(bcd_q), .nxt(dec2));

  ictr_gate_edge u_gate (
    .clk (clk),
    .rst (rst),
    .step(step),
    .gate(gate),
    .rise(rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_TERM;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      cnt_q    <= '0;
      out_q    <= 1'b1;
      have_q   <= 1'b0;
      pend_q   <= 1'b0;
      run_q    <= 1'b0;
      strb_q   <= 1'b0;
      strch_q  <= 1'b0;
    end else if (cfg_we) begin
      mode_q  <= norm_mode(cfg_mode);
      bcd_q   <= cfg_bcd;
      out_q   <= (norm_mode(cfg_mode) != MD_TERM);
      have_q  <= 1'b0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      strb_q  <= 1'b0;
      strch_q <= 1'b0;
    end else if (cnt_we) begin
      reload_q <= cnt_val;
      have_q   <= 1'b1;
      if (mode_q != MD_ONESHOT && mode_q != MD_HWSTROBE) pend_q <= 1'b1;
      if (mode_q == MD_TERM) out_q <= 1'b0;
    end else if (step) begin
      if (strb_q) begin
        out_q  <= 1'b1;
        strb_q <= 1'b0;
      end
      case (mode_q)
        MD_TERM, MD_SWSTROBE: begin
          if (pend_q) begin
            cnt_q  <= reload_q;
            pend_q <= 1'b0;
            run_q  <= 1'b1;
          end else if (run_q && gate) begin
            cnt_q <= dec1;
            if (cnt_q == ONE) begin
              run_q <= 1'b0;
              if (mode_q == MD_TERM) out_q <= 1'b1;
              else begin
                out_q  <= 1'b0;
                strb_q <= 1'b1;
              end
            end
          end
        end
        MD_ONESHOT, MD_HWSTROBE: begin
          if (rise && have_q) begin
            cnt_q <= reload_q;
            run_q <= 1'b1;
            if (mode_q == MD_ONESHOT) out_q <= 1'b0;
          end else if (run_q) begin
            cnt_q <= dec1;
            if (cnt_q == ONE) begin
              run_q <= 1'b0;
              if (mode_q == MD_ONESHOT) out_q <= 1'b1;
              else begin
                out_q  <= 1'b0;
                strb_q <= 1'b1;
              end
            end
          end
        end
        MD_RATE: begin
          if (restart) begin
            cnt_q  <= reload_q;
            out_q  <= 1'b1;
            run_q  <= 1'b1;
            pend_q <= 1'b0;
          end else if (!gate) begin
            out_q <= 1'b1;
          end else if (run_q) begin
            if (cnt_q == ONE) begin
              cnt_q <= reload_q;
              out_q <= 1'b1;
            end else begin
              cnt_q <= dec1;
              if (cnt_q == TWO) out_q <= 1'b0;
            end
          end
        end
        MD_SQUARE: begin
          if (restart) begin
            cnt_q   <= even_rl;
            out_q   <= 1'b1;
            run_q   <= 1'b1;
            pend_q  <= 1'b0;
            strch_q <= 1'b0;
          end else if (!gate) begin
            out_q <= 1'b1;
          end else if (run_q) begin
            if (cnt_q == TWO) begin
              if (out_q && reload_q[0] && !strch_q) begin
                strch_q <= 1'b1;
              end else begin
                out_q   <= ~out_q;
                cnt_q   <= even_rl;
                strch_q <= 1'b0;
              end
            end else begin
              cnt_q <= dec2;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign out = out_q;

endmodule

// File: rtl/ictr_channel_chk.sv
module ictr_channel_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       gate,
  input logic       cfg_we,
  input logic       cnt_we,
  input logic [2:0] cfg_mode,
  input logic [2:0] mode_q,
  input logic       out
);

  p_mode_init_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (out == ($past(cfg_mode) != 3'b000)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cfg_we && !cnt_we) |=> $stable(out));

  p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd0 && out && !cfg_we && !cnt_we) |=> out);

  p_strobe_one_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q[2:1] == 2'b10 && !out && tick && !cfg_we && !cnt_we) |=> out);

  p_gate_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_q[2:1] == 2'b01 && tick && !gate && !cfg_we && !cnt_we) |=> out);

endmodule

bind ictr_channel ictr_channel_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .gate    (gate),
  .cfg_we  (cfg_we),
  .cnt_we  (cnt_we),
  .cfg_mode(cfg_mode),
  .mode_q  (mode_q),
  .out     (out)
);

// File: tb/ictr_channel_bench.sv
module ictr_channel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        gate = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic        cfg_bcd = 1'b0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_val = 16'd0;
  logic        out;

  ictr_channel u_ictr_channel (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
    .cnt_we(cnt_we), .cnt_val(cnt_val), .out(out)
  );

  always #10 clk = ~clk;

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Tick count that a written value stands for.
  function automatic int span(input logic [15:0] raw, input bit dec);
    int v;
    if (dec) v = int'(raw[15:12]) * 1000 + int'(raw[11:8]) * 100 + int'(raw[7:4]) * 10 + int'(raw[3:0]);
    else     v = int'(raw);
    if (v == 0) v = dec ? 10000 : 65536;
    return v;
  endfunction

  // Behavioural reference: integer ticks remaining, no digit arithmetic.
  int          m_mode, m_rem, n;
  bit          m_bcd, m_out, m_pend, m_run, m_have, m_strb, m_gq, rise;
  logic [15:0] m_raw;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_bcd = 0; m_out = 1; m_pend = 0; m_run = 0;
      m_have = 0; m_strb = 0; m_gq = 0; m_rem = 0; m_raw = 16'd0;
    end else if (cfg_we) begin
      m_mode = int'(cfg_mode);
      if ((m_mode & 2) != 0) m_mode = m_mode & 3;
      m_bcd = cfg_bcd; m_out = (m_mode != 0);
      m_have = 0; m_pend = 0; m_run = 0; m_strb = 0;
    end else if (cnt_we) begin
      m_raw = cnt_val; m_have = 1;
      if (m_mode != 1 && m_mode != 5) m_pend = 1;
      if (m_mode == 0) m_out = 0;
    end else if (tick) begin
      n = span(m_raw, m_bcd);
      rise = gate && !m_gq;
      m_gq = gate;
      if (m_strb) begin m_out = 1; m_strb = 0; end
      case (m_mode)
        0, 4: begin
          if (m_pend) begin m_rem = n; m_pend = 0; m_run = 1; end
          else if (m_run && gate) begin
            m_rem--;
            if (m_rem == 0) begin
              m_run = 0;
              if (m_mode == 0) m_out = 1; else begin m_out = 0; m_strb = 1; end
            end
          end
        end
        1, 5: begin
          if (rise && m_have) begin m_rem = n; m_run = 1; if (m_mode == 1) m_out = 0; end
          else if (m_run) begin
            m_rem--;
            if (m_rem == 0) begin
              m_run = 0;
              if (m_mode == 1) m_out = 1; else begin m_out = 0; m_strb = 1; end
            end
          end
        end
        2: begin
          if (m_pend || (rise && m_have)) begin m_rem = n; m_out = 1; m_run = 1; m_pend = 0; end
          else if (!gate) m_out = 1;
          else if (m_run) begin
            m_rem--;
            if (m_rem == 0) begin m_rem = n; m_out = 1; end
            else if (m_rem == 1) m_out = 0;
          end
        end
        3: begin
          if (m_pend || (rise && m_have)) begin m_rem = (n + 1) / 2; m_out = 1; m_run = 1; m_pend = 0; end
          else if (!gate) m_out = 1;
          else if (m_run) begin
            m_rem--;
            if (m_rem == 0) begin
              m_out = !m_out;
              m_rem = m_out ? (n + 1) / 2 : n / 2;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) check(out === m_out, cur_req, int'(out), int'(m_out));
  end

  task automatic wr_mode(input logic [2:0] m, input logic b);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = m; cfg_bcd = b;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v, input logic tk);
    @(negedge clk); cnt_we = 1'b1; cnt_val = v; tick = tk;
    @(negedge clk); cnt_we = 1'b0; tick = 1'b0;
  endtask

  task automatic run(input int cnt, input int div);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); tick = ((i % div) == 0);
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk); gate = v;
  endtask

  task automatic pulse_gate();
    set_gate(1'b0); run(1, 1); set_gate(1'b1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out === 1'b1, "R1", int'(out), 1);
    rst = 1'b0;
    run(6, 1);
    check(out === 1'b1, "R1", int'(out), 1);

    // Mode 0: level rises after the count
    cur_req = "R4";
    wr_mode(3'b000, 1'b0);
    check(out === 1'b0, "R2", int'(out), 0);
    wr_cnt(16'd4, 1'b0);
    run(4, 1);
    check(out === 1'b0, "R4", int'(out), 0);
    run(1, 1);
    check(out === 1'b1, "R4", int'(out), 1);
    run(5, 1);
    cur_req = "R10";
    wr_cnt(16'd6, 1'b0);
    run(3, 1); set_gate(1'b0); run(4, 1); set_gate(1'b1); run(8, 1);

    // Decimal counting and the largest decimal count
    cur_req = "R11";
    wr_mode(3'b000, 1'b1);
    wr_cnt(16'h0012, 1'b1);
    run(20, 1);
    wr_cnt(16'h0000, 1'b0);
    run(10000, 1);
    check(out === 1'b0, "R11", int'(out), 0);
    run(1, 1);
    check(out === 1'b1, "R11", int'(out), 1);

    // Mode 2 rate pulses, gate pause and restart
    cur_req = "R6";
    wr_mode(3'b010, 1'b0);
    wr_cnt(16'd10, 1'b0);
    run(45, 1);
    cur_req = "R10";
    set_gate(1'b0); run(5, 1); set_gate(1'b1); run(30, 1);
    cur_req = "R3";
    wr_cnt(16'd3, 1'b1);
    run(40, 3);

    // Mode 3 odd and even counts
    cur_req = "R7";
    wr_mode(3'b011, 1'b0);
    wr_cnt(16'd11, 1'b0);
    run(60, 1);
    cur_req = "R10";
    set_gate(1'b0); run(4, 1); set_gate(1'b1); run(20, 1);
    cur_req = "R7";
    wr_cnt(16'd4, 1'b0);
    run(30, 2);
    wr_mode(3'b011, 1'b1);
    wr_cnt(16'h0015, 1'b0);
    run(60, 1);

    // Folded mode codes
    cur_req = "R12";
    wr_mode(3'b110, 1'b0);
    wr_cnt(16'd5, 1'b0);
    run(25, 1);
    wr_mode(3'b111, 1'b0);
    wr_cnt(16'd7, 1'b0);
    run(30, 1);

    // Mode 4 single strobe
    cur_req = "R8";
    wr_mode(3'b100, 1'b0);
    check(out === 1'b1, "R2", int'(out), 1);
    wr_cnt(16'd6, 1'b0);
    run(3, 1); set_gate(1'b0); run(3, 1); set_gate(1'b1); run(15, 1);

    // Mode 1 waits for a trigger, then one-shot with retrigger
    cur_req = "R13";
    wr_mode(3'b001, 1'b0);
    wr_cnt(16'd3, 1'b0);
    run(6, 1);
    check(out === 1'b1, "R13", int'(out), 1);
    cur_req = "R5";
    pulse_gate(); run(2, 1);
    check(out === 1'b0, "R5", int'(out), 0);
    pulse_gate(); run(8, 1);
    check(out === 1'b1, "R5", int'(out), 1);

    // Mode 5 gate-started strobe
    cur_req = "R9";
    wr_mode(3'b101, 1'b0);
    wr_cnt(16'd4, 1'b0);
    run(5, 1);
    check(out === 1'b1, "R13", int'(out), 1);
    pulse_gate(); run(8, 1);
    pulse_gate(); run(2, 1); pulse_gate(); run(8, 1);

    // Mode write mid-run resets the output level
    cur_req = "R2";
    wr_mode(3'b010, 1'b0);
    wr_cnt(16'd5, 1'b0);
    run(3, 1);
    wr_mode(3'b000, 1'b0);
    check(out === 1'b0, "R2", int'(out), 0);
    run(4, 1);
    check(out === 1'b0, "R2", int'(out), 0);

    // Largest binary count in mode 2
    cur_req = "R11";
    wr_mode(3'b010, 1'b0);
    wr_cnt(16'd0, 1'b0);
    run(65535, 1);
    check(out === 1'b1, "R11", int'(out), 1);
    run(1, 1);
    check(out === 1'b0, "R11", int'(out), 0);
    run(1, 1);
    check(out === 1'b1, "R11", int'(out), 1);

    finish_run();
  end

endmodule